// File: doc/BRIEF.md
# Swizzled Texel Address Generator

This block turns a texel coordinate (x, y, z) on a surface into the byte address of that texel. The surface is described by a base address, a row pitch in bytes, power-of-two width, height and depth, and the number of bytes per pixel. The descriptor picks one of three memory layouts: plain rows (pitch-linear), a 2D swizzle built from square Morton-ordered tiles placed row after row, or a 3D bit interleave of all three coordinates.

A copy or sampling engine presents one coordinate per cycle together with `in_valid`. The address appears on `out_addr` one clock later, and `out_valid` marks it. Between valid inputs the last address is held. The block does not touch memory. Swizzled surfaces must have power-of-two sizes.

Top module: `texaddr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` becomes 0 and `out_addr` becomes 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_addr` is loaded only when `in_valid` is high and otherwise keeps its value, whatever the other inputs do.
- R3: A nonzero pitch selects the linear layout whatever the depth. With pitch 0, a depth of 0 or 1 selects the 2D swizzle and a depth of 2 or more selects the 3D interleave.
- R4: Linear layout: address = base + y * pitch + x * bpp.
- R5: 2D swizzle, inside a tile: let k = log2(min(width, height)). For each i < k, bit i of x is placed at index bit 2i and bit i of y at index bit 2i+1.
- R6: 2D swizzle, tile placement: the tiles are 2^k by 2^k and are placed row-major. The tile number (y >> k) * (width >> k) + (x >> k) is shifted left by 2k and added to the in-tile index.
- R7: 3D interleave: in each round the next unused bit of x, then of y, then of z goes to the next free index bit. An axis takes part only while fewer than log2(size) of its bits have been used, so a size-1 axis adds nothing and x bits at or above log2(width) are ignored. The interleave ends at the first round in which no axis adds a bit.
- R8: Both swizzled layouts give address = base + index * bpp.
- R9: All address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Coordinate and descriptor are valid this cycle |
| in_base | input | ADDR_W | Surface base byte address |
| in_pitch | input | PITCH_W | Row pitch in bytes; 0 means swizzled |
| in_width | input | DIM_W | Surface width in texels (power of two when swizzled) |
| in_height | input | DIM_W | Surface height in texels (power of two when swizzled) |
| in_depth | input | DIM_W | Surface depth in texels (power of two when swizzled) |
| in_bpp | input | BPP_W | Bytes per pixel |
| in_x | input | COORD_W | Texel x coordinate |
| in_y | input | COORD_W | Texel y coordinate |
| in_z | input | COORD_W | Texel z coordinate |
| out_valid | output | 1 | `out_addr` holds a new result |
| out_addr | output | ADDR_W | Texel byte address |

## Verification
The assertions check on every cycle the one-cycle valid timing and the hold of the address between valid inputs. They also check the cases whose result is fixed in every layout: a coordinate at the origin gives exactly the base address, a unit step in x on a 2D surface moves the address by one pixel, and a unit step in y on a 3D surface moves it by two pixels. The full bit placement can only be shown by the bench. This covers the Morton order inside a tile, row-major tile placement on wide and tall surfaces, and round-robin interleaving when the three axes run out of bits at different rounds. The bench also covers dropped x bits, depth 0/1 against depth 2, and wrap-around of the address. It does this with directed surfaces and random ones checked against its own model.

// File: rtl/texaddr_pkg.sv
// Package: shared types for the texel address generator.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package texaddr_pkg;

    // Memory layout chosen from the surface descriptor.
    typedef enum logic [1:0] {
        LAY_LINEAR  = 2'd0,
        LAY_TILED2D = 2'd1,
        LAY_CUBE3D  = 2'd2
    } layout_e;

endpackage

// File: rtl/texaddr_log2.sv
// Module: texaddr_log2
// Priority encoder returning the index of the highest set bit of value.
// Assumes value is a power of two, so the result is its exact log2.
// A zero input yields 0.
module texaddr_log2 #(
    parameter int IN_W  = 13,
    parameter int OUT_W = 4
) (
    input  logic [IN_W-1:0]  value,
    output logic [OUT_W-1:0] log_out
);

    // Scan upward so the highest set bit wins.
    always_comb begin
        log_out = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (value[i]) log_out = OUT_W'(i);
        end
    end

endmodule

// File: rtl/texaddr_tile2d.sv
// Module: texaddr_tile2d
// Element index for the 2D swizzled layout: Morton order inside square
// tiles of side 2^k, with the tiles placed row-major across the surface.
// Assumes width is a power of two and k = log2(min(width, height)).
module texaddr_tile2d #(
    parameter int COORD_W = 12,
    parameter int DIM_W   = 13,
    parameter int LOG_W   = 4,
    parameter int ADDR_W  = 32
) (
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [DIM_W-1:0]   width,
    input  logic [LOG_W-1:0]   k,
    output logic [ADDR_W-1:0]  index
);

    localparam int SPREAD_W = 2 * COORD_W;

    logic [COORD_W:0]    k_onehot;
    logic [COORD_W-1:0]  k_mask;
    logic [SPREAD_W-1:0] inner;
    logic [ADDR_W-1:0]   tile_num;
    logic [LOG_W:0]      tile_shift;

    // Mask that keeps the low k bits of each coordinate.
    assign k_onehot = (COORD_W + 1)'(1) << k;
    assign k_mask   = COORD_W'(k_onehot - (COORD_W + 1)'(1));

    // Spread the masked coordinate bits: x to even, y to odd positions.
    for (genvar i = 0; i < COORD_W; i++) begin : g_spread
        assign inner[2*i]   = x[i] & k_mask[i];
        assign inner[2*i+1] = y[i] & k_mask[i];
    end

    // Row-major tile number and its offset of 2k bits.
    assign tile_num   = ADDR_W'(y >> k) * ADDR_W'(width >> k) + ADDR_W'(x >> k);
    assign tile_shift = {k, 1'b0};

    // Combine the tile base with the in-tile Morton index.
    assign index = (tile_num << tile_shift) + ADDR_W'(inner);

endmodule

// File: rtl/texaddr_cube3d.sv
// Module: texaddr_cube3d
// Element index for the 3D interleaved layout: round-robin x, y, z bits,
// each axis dropping out once log2(size) of its bits have been placed.
// Assumes the per-axis logs are at most COORD_W.
module texaddr_cube3d #(
    parameter int COORD_W = 12,
    parameter int LOG_W   = 4,
    parameter int ADDR_W  = 32
) (
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [COORD_W-1:0] z,
    input  logic [LOG_W-1:0]   log_w,
    input  logic [LOG_W-1:0]   log_h,
    input  logic [LOG_W-1:0]   log_d,
    output logic [ADDR_W-1:0]  index
);

    localparam int IDX_W = 3 * COORD_W;
    localparam int POS_W = $clog2(IDX_W + 1);

    logic [IDX_W-1:0] bits;

    // Walk the rounds, appending one bit per still-active axis.
    always_comb begin
        logic [POS_W-1:0] pos;
        pos  = '0;
        bits = '0;
        for (int r = 0; r < COORD_W; r++) begin
            if (r < int'(log_w)) begin
                bits[pos] = x[r];
                pos = pos + POS_W'(1);
            end
            if (r < int'(log_h)) begin
                bits[pos] = y[r];
                pos = pos + POS_W'(1);
            end
            if (r < int'(log_d)) begin
                bits[pos] = z[r];
                pos = pos + POS_W'(1);
            end
        end
    end

    assign index = ADDR_W'(bits);

endmodule

// File: rtl/texaddr_gen.sv
// Module: texaddr_gen (top)
// Texel byte address generator for linear, 2D swizzled and 3D interleaved
// surfaces. One coordinate per cycle; result registered one cycle later.
// Assumes power-of-two width/height/depth for swizzled surfaces.
module texaddr_gen
    import texaddr_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 16,
    parameter int COORD_W = 12,
    parameter int BPP_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  in_base,
    input  logic [PITCH_W-1:0] in_pitch,
    input  logic [COORD_W:0]   in_width,
    input  logic [COORD_W:0]   in_height,
    input  logic [COORD_W:0]   in_depth,
    input  logic [BPP_W-1:0]   in_bpp,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic [COORD_W-1:0] in_z,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr
);

    localparam int DIM_W = COORD_W + 1;
    localparam int LOG_W = $clog2(DIM_W);

    layout_e           layout;
    logic [DIM_W-1:0]  dims [3];
    logic [LOG_W-1:0]  logs [3];
    logic [LOG_W-1:0]  tile_k;
    logic [ADDR_W-1:0] idx_2d;
    logic [ADDR_W-1:0] idx_3d;
    logic [ADDR_W-1:0] idx_swz;
    logic [ADDR_W-1:0] addr_lin;
    logic [ADDR_W-1:0] addr_next;

    assign dims[0] = in_width;
    assign dims[1] = in_height;
    assign dims[2] = in_depth;

    // One log2 encoder per axis.
    for (genvar g = 0; g < 3; g++) begin : g_log
        texaddr_log2 #(
            .IN_W  (DIM_W),
            .OUT_W (LOG_W)
        ) u_log (
            .value   (dims[g]),
            .log_out (logs[g])
        );
    end

    // Tile side: log of the smaller of width and height.
    assign tile_k = (logs[0] < logs[1]) ? logs[0] : logs[1];

    // Decide the layout from pitch and depth.
    always_comb begin
        if (in_pitch != '0)
            layout = LAY_LINEAR;
        else if (in_depth <= DIM_W'(1))
            layout = LAY_TILED2D;
        else
            layout = LAY_CUBE3D;
    end

    texaddr_tile2d #(
        .COORD_W (COORD_W),
        .DIM_W   (DIM_W),
        .LOG_W   (LOG_W),
        .ADDR_W  (ADDR_W)
    ) u_tile2d (
        .x     (in_x),
        .y     (in_y),
        .width (in_width),
        .k     (tile_k),
        .index (idx_2d)
    );

    texaddr_cube3d #(
        .COORD_W (COORD_W),
        .LOG_W   (LOG_W),
        .ADDR_W  (ADDR_W)
    ) u_cube3d (
        .x     (in_x),
        .y     (in_y),
        .z     (in_z),
        .log_w (logs[0]),
        .log_h (logs[1]),
        .log_d (logs[2]),
        .index (idx_3d)
    );

    // Linear byte address from row and column.
    assign addr_lin = in_base + ADDR_W'(in_y) * ADDR_W'(in_pitch)
                              + ADDR_W'(in_x) * ADDR_W'(in_bpp);

    // Scale the swizzled element index to bytes and pick the result.
    always_comb begin
        idx_swz   = (layout == LAY_CUBE3D) ? idx_3d : idx_2d;
        addr_next = (layout == LAY_LINEAR) ? addr_lin
                                           : in_base + idx_swz * ADDR_W'(in_bpp);
    end

    // Output register: capture on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_addr <= addr_next;
        end
    end

endmodule

// File: rtl/texaddr_gen_chk.sv
// Module: texaddr_gen_chk
// Property checker bound to texaddr_gen. Watches only ports.
// Assumes the same parameters as the bound instance.
module texaddr_gen_chk #(
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 16,
    parameter int COORD_W = 12,
    parameter int BPP_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [ADDR_W-1:0]  in_base,
    input logic [PITCH_W-1:0] in_pitch,
    input logic [COORD_W:0]   in_width,
    input logic [COORD_W:0]   in_height,
    input logic [COORD_W:0]   in_depth,
    input logic [BPP_W-1:0]   in_bpp,
    input logic [COORD_W-1:0] in_x,
    input logic [COORD_W-1:0] in_y,
    input logic [COORD_W-1:0] in_z,
    input logic               out_valid,
    input logic [ADDR_W-1:0]  out_addr
);

    localparam int DIM_W = COORD_W + 1;

    p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_addr));

    p_linear_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_pitch != '0 && in_x == '0 && in_y == '0)
        |=> out_addr == $past(in_base));

    p_swz_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_pitch == '0 && in_x == '0 && in_y == '0 && in_z == '0)
        |=> out_addr == $past(in_base));

    p_tile_x_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_pitch == '0 && in_depth <= DIM_W'(1)
         && in_width >= DIM_W'(2) && in_height >= DIM_W'(2)
         && in_x == COORD_W'(1) && in_y == '0)
        |=> out_addr == $past(in_base) + ADDR_W'($past(in_bpp)));

    p_cube_y_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_pitch == '0 && in_depth >= DIM_W'(2)
         && in_width >= DIM_W'(2) && in_height >= DIM_W'(2)
         && in_x == '0 && in_y == COORD_W'(1) && in_z == '0)
        |=> out_addr == $past(in_base) + ADDR_W'($past(in_bpp)) * ADDR_W'(2));

endmodule

bind texaddr_gen texaddr_gen_chk #(
    .ADDR_W  (ADDR_W),
    .PITCH_W (PITCH_W),
    .COORD_W (COORD_W),
    .BPP_W   (BPP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_base   (in_base),
    .in_pitch  (in_pitch),
    .in_width  (in_width),
    .in_height (in_height),
    .in_depth  (in_depth),
    .in_bpp    (in_bpp),
    .in_x      (in_x),
    .in_y      (in_y),
    .in_z      (in_z),
    .out_valid (out_valid),
    .out_addr  (out_addr)
);

// File: tb/texaddr_gen_bench.sv
`timescale 1ns/1ps
module texaddr_gen_bench;

    localparam int ADDR_W  = 32;
    localparam int PITCH_W = 16;
    localparam int COORD_W = 12;
    localparam int BPP_W   = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [ADDR_W-1:0]  in_base = '0;
    logic [PITCH_W-1:0] in_pitch = '0;
    logic [COORD_W:0]   in_width = '0;
    logic [COORD_W:0]   in_height = '0;
    logic [COORD_W:0]   in_depth = '0;
    logic [BPP_W-1:0]   in_bpp = '0;
    logic [COORD_W-1:0] in_x = '0;
    logic [COORD_W-1:0] in_y = '0;
    logic [COORD_W-1:0] in_z = '0;
    logic               out_valid;
    logic [ADDR_W-1:0]  out_addr;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    texaddr_gen #(
        .ADDR_W  (ADDR_W),
        .PITCH_W (PITCH_W),
        .COORD_W (COORD_W),
        .BPP_W   (BPP_W)
    ) u_texaddr_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_base   (in_base),
        .in_pitch  (in_pitch),
        .in_width  (in_width),
        .in_height (in_height),
        .in_depth  (in_depth),
        .in_bpp    (in_bpp),
        .in_x      (in_x),
        .in_y      (in_y),
        .in_z      (in_z),
        .out_valid (out_valid),
        .out_addr  (out_addr)
    );

    // Independent model of the three layouts.
    function automatic logic [31:0] model_addr(logic [31:0] base, logic [31:0] pitch,
            logic [31:0] w, logic [31:0] h, logic [31:0] d, logic [31:0] bpp,
            logic [31:0] x, logic [31:0] y, logic [31:0] z);
        logic [31:0] idx, inner, tile, m, hw, hh, hd, xs, ys, zs;
        int k, pos, start;
        if (pitch != 0) return base + y * pitch + x * bpp;
        idx = 0;
        if (d <= 1) begin
            m = (w < h) ? w : h;
            k = 0;
            for (int i = 0; i < 16; i++) if ((32'd1 << i) == m) k = i;
            inner = 0;
            for (int i = 0; i < k; i++) begin
                inner |= ((x >> i) & 1) << (2 * i);
                inner |= ((y >> i) & 1) << (2 * i + 1);
            end
            tile = (y >> k) * (w >> k) + (x >> k);
            idx = (tile << (2 * k)) + inner;
        end else begin
            hw = w >> 1; hh = h >> 1; hd = d >> 1;
            xs = x; ys = y; zs = z; pos = 0;
            for (int guard = 0; guard < 64; guard++) begin
                start = pos;
                if (hw != 0) begin idx |= (xs & 1) << pos; pos++; xs >>= 1; hw >>= 1; end
                if (hh != 0) begin idx |= (ys & 1) << pos; pos++; ys >>= 1; hh >>= 1; end
                if (hd != 0) begin idx |= (zs & 1) << pos; pos++; zs >>= 1; hd >>= 1; end
                if (start == pos) break;
            end
        end
        return base + idx * bpp;
    endfunction

    task automatic check(string req, logic [31:0] actual, logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, actual, expected);
        end
    endtask

    // Drive one valid coordinate at a falling edge, check after the next rise.
    task automatic run_case(string req, logic [31:0] base, logic [31:0] pitch,
            logic [31:0] w, logic [31:0] h, logic [31:0] d, logic [31:0] bpp,
            logic [31:0] x, logic [31:0] y, logic [31:0] z,
            bit use_lit, logic [31:0] lit);
        logic [31:0] exp;
        exp = use_lit ? lit : model_addr(base, pitch, w, h, d, bpp, x, y, z);
        in_base = base; in_pitch = PITCH_W'(pitch);
        in_width = (COORD_W+1)'(w); in_height = (COORD_W+1)'(h); in_depth = (COORD_W+1)'(d);
        in_bpp = BPP_W'(bpp);
        in_x = COORD_W'(x); in_y = COORD_W'(y); in_z = COORD_W'(z);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check(req, out_addr, exp);
    endtask

    initial begin
        #(100000 * 5.0);
        if (!finished) begin
            failures++;
            $display("FAIL R2 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        // R1: reset state
        in_base = 32'hDEAD_BEEF; in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 addr", out_addr, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R4 linear, literal
        run_case("R4", 32'h1000, 256, 64, 64, 1, 4, 3, 2, 0, 1, 32'h120C);
        // R3: nonzero pitch stays linear even with depth 8
        run_case("R3 linear-depth", 32'h1000, 256, 64, 64, 8, 4, 3, 2, 5, 1, 32'h120C);
        // R5: square 8x8, bpp 1, x=5 y=3 -> 27
        run_case("R5", 0, 0, 8, 8, 1, 1, 5, 3, 0, 1, 32'd27);
        // R3: depth 0 is also 2D
        run_case("R3 depth0", 0, 0, 8, 8, 0, 1, 5, 3, 0, 1, 32'd27);
        // R6: wide 16x4, x=9 y=2 -> 41
        run_case("R6 wide", 0, 0, 16, 4, 1, 1, 9, 2, 0, 1, 32'd41);
        // R6: tall 4x16, x=1 y=9 -> 35
        run_case("R6 tall", 0, 0, 4, 16, 1, 1, 1, 9, 0, 1, 32'd35);
        // R6: 2-wide edge case
        run_case("R6 two-wide", 32'h400, 0, 2, 8, 1, 2, 1, 5, 0, 0, 0);
        // R7: cube 4x4x4 x=1 y=2 z=3 -> 53
        run_case("R7 cube", 0, 0, 4, 4, 4, 1, 1, 2, 3, 1, 32'd53);
        // R7/R8: 8x2x4 x=5 y=1 z=2, bpp 2, base 0x100 -> 0x100+102
        run_case("R8 uneven", 32'h100, 0, 8, 2, 4, 2, 5, 1, 2, 1, 32'h166);
        // R3: depth 2 with pitch 0 is 3D: 4x4x2, x=0 y=0 z=1 -> idx 4
        run_case("R3 depth2", 0, 0, 4, 4, 2, 1, 0, 0, 1, 1, 32'd4);
        // R7: x bits above log2(width) ignored: 4x4x4, x=5 equals x=1
        run_case("R7 drop-x", 0, 0, 4, 4, 4, 1, 5, 2, 3, 1, 32'd53);
        // R9: wrap-around
        run_case("R9", 32'hFFFF_FFF0, 16, 64, 64, 1, 4, 4, 1, 0, 1, 32'h0000_0010);

        // R2: hold while idle with changed inputs
        held = out_addr;
        in_base = 32'h5555_0000; in_x = 12'd7; in_pitch = 16'd4;
        @(negedge clk);
        check("R2 idle valid", {31'd0, out_valid}, 32'd0);
        check("R2 hold", out_addr, held);

        // Random surfaces against the model
        for (int n = 0; n < 400; n++) begin
            int mode;
            logic [31:0] w, h, d, p, bpp;
            mode = $urandom_range(0, 2);
            case ($urandom_range(0, 2))
                0: bpp = 1;
                1: bpp = 2;
                default: bpp = 4;
            endcase
            if (mode == 0) begin
                w = $urandom_range(1, 4095); h = $urandom_range(1, 4095);
                d = $urandom_range(0, 8); p = $urandom_range(1, 65535);
                run_case("R4 rand", $urandom, p, w, h, d, bpp,
                         $urandom_range(0, w - 1), $urandom_range(0, h - 1),
                         $urandom_range(0, 7), 0, 0);
            end else if (mode == 1) begin
                w = 32'd1 << $urandom_range(0, 8); h = 32'd1 << $urandom_range(0, 8);
                d = $urandom_range(0, 1);
                run_case("R6 rand", $urandom, 0, w, h, d, bpp,
                         $urandom_range(0, w - 1), $urandom_range(0, h - 1),
                         0, 0, 0);
            end else begin
                w = 32'd1 << $urandom_range(0, 6); h = 32'd1 << $urandom_range(0, 6);
                d = 32'd1 << $urandom_range(1, 6);
                run_case("R7 rand", $urandom, 0, w, h, d, bpp,
                         $urandom_range(0, w - 1), $urandom_range(0, h - 1),
                         $urandom_range(0, d - 1), 0, 0);
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule